// File: doc/BRIEF.md
# Serial Clock Pattern Generator

This block turns a spare serial transceiver lane into a clock output. Every cycle it hands the serializer one parallel word. The bits of these words are chosen so that the serialized line stream is a square wave. Its period, counted in line bits, equals a programmable ratio. A write to a single control register selects the ratio, which is one of 10, 20, 30, 40 or 50. The ratio is always taken against the real serial bit rate, oversampling included. Examples: a 1.485 Gb/s lane at ratio 10 gives 148.5 MHz, a 5.94 Gb/s lane at ratio 40 gives 148.5 MHz, and a 3x-oversampled 270 Mb/s stream at ratio 30 gives 27 MHz.

A 40-bit word is not in general a multiple of the ratio. The block therefore keeps a phase counter modulo the ratio, and the waveform runs on without a break from one word to the next. A mode input chooses what drives the lane:

- In clock mode, the lane carries the generated pattern.
- In link-data mode, the lane carries an incoming data word unchanged.

Both paths pass through one output register.

Top module: `tmds_clkpat_gen`

## Requirements
- R1: While reset is held, `lane_data` is all zeros. After reset the ratio is 10 and the phase is 0. The first clock-mode word is therefore 40'h07C1F07C1F.
- R2: In clock mode, bit i of each word (bit 0 is sent first) is 1 exactly when (phase + i) mod ratio < ratio/2. This gives a 50% duty square wave whose period is the ratio in line bits.
- R3: From one clock-mode word to the next, the phase advances by 40 modulo the ratio. The waveform stays continuous for ratios 30 and 50, which do not divide 40.
- R4: A write with `cfg_wr_en` high and `cfg_addr` equal to 12'h340 whose data is exactly 10, 20, 30, 40 or 50 sets the ratio. The new ratio applies to the word registered at that same clock edge.
- R5: A write to 12'h340 with any other data value is ignored. The ratio and the phase progression continue unchanged.
- R6: A write to any address other than 12'h340 is ignored.
- R7: An accepted write that changes the ratio restarts the phase at 0. The next output word begins with a high half-period. A write of the current ratio does not restart the phase.
- R8: While `mode_frl` is 1, `lane_data` equals the `frl_data` value present before the previous clock edge. The latency is one cycle.
- R9: The first clock-mode word after `mode_frl` falls starts at phase 0 with the current ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Control register write strobe |
| cfg_addr | input | 12 | Control register byte address |
| cfg_wdata | input | 32 | Write data; the ratio as an unsigned value |
| mode_frl | input | 1 | 1 selects link data, 0 selects the clock pattern |
| frl_data | input | 40 | Link data word for pass-through |
| lane_data | output | 40 | Registered parallel word to the serializer |

## Verification
A phase counter that is off by any amount shows up in the very next clock-mode word. In that word the position of the first falling edge moves away from (ratio/2 − phase). The fault is visible one edge after the faulty state appears. A ratio register that takes an illegal or misaddressed write changes the run length of ones within one cycle. A restart that is missed shows as a word beginning with zeros. Mux or latency faults show as a link word that arrives shifted by a cycle or never arrives.

// File: rtl/tmds_pat_pkg.sv
package tmds_pat_pkg;

    localparam int RATIO_W = 6;

    // Legal ratios of line bit rate to output clock.
    function automatic logic ratio_ok(input logic [RATIO_W-1:0] r);
        return (r == 6'd10) || (r == 6'd20) || (r == 6'd30) ||
               (r == 6'd40) || (r == 6'd50);
    endfunction

    // Level of the line bit at position pos of a square wave of period r.
    function automatic logic clk_bit(input int pos, input logic [RATIO_W-1:0] r);
        case (r)
            6'd20:   return (pos % 20) < 10;
            6'd30:   return (pos % 30) < 15;
            6'd40:   return (pos % 40) < 20;
            6'd50:   return (pos % 50) < 25;
            default: return (pos % 10) < 5;
        endcase
    endfunction

    // Position pos reduced modulo r.
    function automatic logic [RATIO_W-1:0] wrap(input int pos, input logic [RATIO_W-1:0] r);
        case (r)
            6'd20:   return RATIO_W'(pos % 20);
            6'd30:   return RATIO_W'(pos % 30);
            6'd40:   return RATIO_W'(pos % 40);
            6'd50:   return RATIO_W'(pos % 50);
            default: return RATIO_W'(pos % 10);
        endcase
    endfunction

endpackage

// File: rtl/tmds_ratio_reg.sv
module tmds_ratio_reg
    import tmds_pat_pkg::*;
#(
    parameter int               AW     = 12,
    parameter int               DW     = 32,
    parameter logic [AW-1:0]    OFFSET = 12'h340
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [DW-1:0]      wdata,
    output logic [RATIO_W-1:0] ratio_q,
    output logic [RATIO_W-1:0] ratio_nxt,
    output logic               changed
);
    typedef struct packed {
        logic [RATIO_W-1:0] ratio;
    } st_t;

    st_t st_d, st_q;
    logic hit;
    logic upper_zero;

    always_comb begin
        upper_zero = (wdata >> RATIO_W) == '0;
        hit        = wr_en && (addr == OFFSET) && upper_zero &&
                     ratio_ok(wdata[RATIO_W-1:0]);
        st_d       = st_q;
        if (hit) st_d.ratio = wdata[RATIO_W-1:0];
        changed    = hit && (wdata[RATIO_W-1:0] != st_q.ratio);
        ratio_nxt  = st_d.ratio;
        ratio_q    = st_q.ratio;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.ratio <= 6'd10;
        else        st_q       <= st_d;
    end

    // R4: the stored ratio is always one of the supported values
    p_ratio_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_ok(ratio_q));

    // R5: an illegal value written to the register leaves the ratio alone
    p_bad_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFFSET && !(upper_zero && ratio_ok(wdata[RATIO_W-1:0])))
        |=> $stable(ratio_q));

    // R6: writes elsewhere leave the ratio alone
    p_other_addr_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != OFFSET) |=> $stable(ratio_q));
endmodule

// File: rtl/tmds_phase_engine.sv
module tmds_phase_engine
    import tmds_pat_pkg::*;
#(
    parameter int WORD_W = 40
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_use,
    input  logic [RATIO_W-1:0] ratio_cur,
    input  logic               restart,
    output logic [WORD_W-1:0]  pat_word
);
    typedef struct packed {
        logic [RATIO_W-1:0] phase;
    } st_t;

    st_t st_d, st_q;
    logic [RATIO_W-1:0] phase_use;

    always_comb begin
        phase_use  = restart ? '0 : st_q.phase;
        st_d.phase = wrap(int'(phase_use) + WORD_W, ratio_use);
    end

    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        assign pat_word[i] = clk_bit(int'(phase_use) + i, ratio_use);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.phase <= '0;
        else        st_q       <= st_d;
    end

    // R3: the phase stays inside one period of the active ratio
    p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase < ratio_cur);
endmodule

// File: rtl/tmds_clkpat_gen.sv
module tmds_clkpat_gen
    import tmds_pat_pkg::*;
#(
    parameter int            WORD_W = 40,
    parameter int            AW     = 12,
    parameter int            DW     = 32,
    parameter logic [AW-1:0] OFFSET = 12'h340
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [DW-1:0]     cfg_wdata,
    input  logic              mode_frl,
    input  logic [WORD_W-1:0] frl_data,
    output logic [WORD_W-1:0] lane_data
);
    typedef struct packed {
        logic [WORD_W-1:0] lane;
        logic              mode;
    } st_t;

    st_t st_d, st_q;
    logic [RATIO_W-1:0] ratio_q, ratio_nxt;
    logic               ratio_chg;
    logic               restart;
    logic [WORD_W-1:0]  pat_word;

    tmds_ratio_reg #(.AW(AW), .DW(DW), .OFFSET(OFFSET)) u_ratio (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .ratio_q   (ratio_q),
        .ratio_nxt (ratio_nxt),
        .changed   (ratio_chg)
    );

    tmds_phase_engine #(.WORD_W(WORD_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio_use (ratio_nxt),
        .ratio_cur (ratio_q),
        .restart   (restart),
        .pat_word  (pat_word)
    );

    always_comb begin
        restart   = ratio_chg || (!mode_frl && st_q.mode);
        st_d.mode = mode_frl;
        st_d.lane = mode_frl ? frl_data : pat_word;
        lane_data = st_q.lane;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lane <= '0;
            st_q.mode <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: link data appears one edge later, unchanged
    p_frl_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_frl |=> lane_data == $past(frl_data));

    // R9: entering clock mode begins with a high half-period
    p_tmds_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_frl && st_q.mode) |=> lane_data[0]);

    // R7: a ratio change in clock mode begins with a high half-period
    p_ratio_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_chg && !mode_frl) |=> lane_data[0]);
endmodule

// File: tb/tmds_clkpat_gen_bench.sv
module tmds_clkpat_gen_bench;
    localparam int W = 40;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_wr_en;
    logic [11:0]   cfg_addr;
    logic [31:0]   cfg_wdata;
    logic          mode_frl;
    logic [W-1:0]  frl_data;
    logic [W-1:0]  lane_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // bench model state
    int m_ratio;
    int m_phase;
    bit m_mode_prev;

    always #5 clk = ~clk;

    tmds_clkpat_gen u_tmds_clkpat_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr_en (cfg_wr_en),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .mode_frl  (mode_frl),
        .frl_data  (frl_data),
        .lane_data (lane_data)
    );

    function automatic logic [W-1:0] pattern(input int ph, input int r);
        logic [W-1:0] w;
        for (int i = 0; i < W; i++) w[i] = ((ph + i) % r) < (r / 2);
        return w;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // One clock: predict from current inputs, clock, compare.
    task automatic step(input string req);
        bit accept, chg, rs;
        int r_use, ph_use;
        logic [W-1:0] exp;
        accept = cfg_wr_en && cfg_addr == 12'h340 &&
                 (cfg_wdata == 10 || cfg_wdata == 20 || cfg_wdata == 30 ||
                  cfg_wdata == 40 || cfg_wdata == 50);
        chg    = accept && int'(cfg_wdata) != m_ratio;
        rs     = chg || (!mode_frl && m_mode_prev);
        r_use  = accept ? int'(cfg_wdata) : m_ratio;
        ph_use = rs ? 0 : m_phase;
        exp    = mode_frl ? frl_data : pattern(ph_use, r_use);
        m_phase     = (ph_use + W) % r_use;
        m_ratio     = r_use;
        m_mode_prev = mode_frl;
        @(posedge clk);
        #1;
        cfg_wr_en = 1'b0;
        chk(req, lane_data, exp);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        cfg_wr_en = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        mode_frl = 1'b0; frl_data = '0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset output", lane_data, '0);
        rst_n = 1'b1;
        m_ratio = 10; m_phase = 0; m_mode_prev = 1'b1;
        step("R1 first word");
        chk("R1 first word constant", lane_data, 40'h07C1F07C1F);
        step("R2 ratio10 steady");
    endtask

    task automatic t_ratios();
        int rs[5] = '{10, 20, 30, 40, 50};
        foreach (rs[k]) begin
            wr(12'h340, rs[k]);
            step("R4 ratio write");
            chk("R7 restart bit0", {39'd0, lane_data[0]}, 40'd1);
            repeat (6) step("R3 continuity");
        end
        wr(12'h340, 40);
        step("R4 ratio 40");
        chk("R2 ratio40 constant", lane_data, 40'h00000FFFFF);
        wr(12'h340, 50);
        step("R4 ratio 50");
        chk("R2 ratio50 word0", lane_data, 40'h0001FFFFFF);
        step("R3 ratio50 word1");
        chk("R3 ratio50 word1 constant", lane_data, 40'h7FFFFFC00);
    endtask

    task automatic t_bad_value();
        wr(12'h340, 30);
        step("R4 set 30");
        step("R3 30 run");
        wr(12'h340, 25);
        step("R5 value 25 ignored");
        wr(12'h340, 0);
        step("R5 value 0 ignored");
        wr(12'h340, 32'h0000_010A);
        step("R5 upper bits ignored");
        repeat (3) step("R5 ratio kept");
    endtask

    task automatic t_wrong_addr();
        wr(12'h344, 20);
        step("R6 other addr ignored");
        wr(12'h240, 50);
        step("R6 other addr ignored");
        repeat (3) step("R6 ratio kept");
    endtask

    task automatic t_restart();
        wr(12'h340, 30);
        step("R7 same value no restart");
        step("R7 run");
        wr(12'h340, 20);
        step("R7 change restarts");
        chk("R7 restart word", lane_data, pattern(0, 20));
        repeat (2) step("R7 after");
    endtask

    task automatic t_frl();
        mode_frl = 1'b1;
        frl_data = 40'hA5_1234_5678;
        step("R8 frl pass");
        frl_data = 40'h3C_DEAD_BEEF;
        step("R8 frl pass");
        chk("R8 frl value", lane_data, 40'h3C_DEAD_BEEF);
        wr(12'h340, 50);
        frl_data = 40'h00_0000_0001;
        step("R8 frl with write");
    endtask

    task automatic t_reentry();
        mode_frl = 1'b0;
        step("R9 reentry");
        chk("R9 phase zero", lane_data, pattern(0, 50));
        repeat (4) step("R9 continue");
    endtask

    initial begin
        t_reset();
        t_ratios();
        t_bad_value();
        t_wrong_addr();
        t_restart();
        t_frl();
        t_reentry();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog act=timeout exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule